// File: doc/BRIEF.md
# Dual Timer/Counter with Shared Mode and Control Registers

This block holds two 16-bit counting channels for a small microcontroller subsystem. Each channel either counts machine cycles (timer) or counts falling transitions on its own external input (counter). Software picks one of four counting modes per channel: a 13-bit prescaled count, a full 16-bit count, an 8-bit count that reloads itself, and, on channel 0 only, a split into two independent 8-bit timers. A per-channel run bit starts and stops counting. An optional per-channel gate lets an external level pin hold the count.

Software reaches six byte-wide registers through one address/data port: a mode register, a control register (run bits and overflow flags), and the low and high count bytes of each channel. The machine-cycle rate comes in as a one-clock enable pulse. Each overflow raises a flag that is visible as an output, so that an interrupt controller can take it. That controller clears the flag again through a dedicated clear input.

Top module: `twin_timer`

## Requirements
- R1: After reset all six registers read 0x00 and both overflow flag outputs are low.
- R2: A running channel in timer mode advances by exactly one per `tickEn` pulse and never without one.
- R3: In counter mode a running channel advances by one when its `cntIn` bit was high at one tick sample and low at the next tick sample. Steady levels cause no count.
- R4: Control bit 4 runs channel 0 and control bit 6 runs channel 1. With its run bit at 0 a channel holds its value.
- R5: In mode 1 the high:low bytes form one 16-bit counter. Wrapping from 0xFFFF to 0x0000 sets the channel's flag (control bit 5 for channel 0, bit 7 for channel 1), which also drives `ovfFlag[ch]`.
- R6: In mode 0 the low 5 bits of the low byte count below the 8-bit high byte (13 bits in total). Low-byte bits 7..5 keep their value, and wrapping from all ones sets the flag.
- R7: In mode 2 the low byte counts. On passing 0xFF it loads the high byte and sets the flag, and the high byte does not change.
- R8: When a channel's gate bit is 1 it counts only while its `gateIn` bit is high. When the gate bit is 0, `gateIn` has no effect.
- R9: A pulse on `flagClr[ch]` clears that flag. An overflow in the same cycle wins over the clear.
- R10: In mode 3 on channel 0 the low byte is an 8-bit counter using run bit 4 and flag bit 5. The high byte is an 8-bit machine-cycle timer using run bit 6 and flag bit 7.
- R11: Channel 1 set to mode 3 holds its count.
- R12: Register addresses are 0 mode, 1 control, 2 low 0, 3 high 0, 4 low 1, 5 high 1. The mode register's upper nibble configures channel 1 and its lower nibble channel 0, each nibble holding {gate, counter-select, mode[1:0]} from MSB to LSB. Control bits 3..0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-clock pulse per machine cycle |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for write and read |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for `regAddr` (combinational) |
| cntIn | input | 2 | External count inputs, bit per channel |
| gateIn | input | 2 | External gate inputs, bit per channel |
| flagClr | input | 2 | Hardware clear of each overflow flag |
| ovfFlag | output | 2 | Overflow flags, bit per channel |

## Verification
Random start values close to and far from the wrap point, combined with random tick counts, are run in the 16-bit mode and in the reloading 8-bit mode. These runs separate correct carry and reload behaviour from off-by-one errors and from a missing or extra flag. Directed cases apply each remaining mode once. The 13-bit case shows that the upper low-byte bits are kept. The split case shows which run bit and flag belong to each half. The counter test holds a steady high level across several ticks, then a single fall, which separates edge counting from level counting. The gate test toggles the gate pin with the gate bit both on and off.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int BYTE_W = 8;
  localparam int CH_N = 2;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LO1  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_HI1  = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic [CH_N-1:0] step;    // advance channel count this cycle
    logic            stepHi0; // advance channel-0 high byte in split mode
    logic [1:0]      mode0;
    logic [1:0]      mode1;
  } tmrStrobe_t;
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic [CH_N-1:0]   cntIn,
  input  logic [CH_N-1:0]   gateIn,
  input  logic [CH_N-1:0]   flagClr,
  input  logic [CH_N-1:0]   wrapEv,
  input  logic              wrapHi0,
  output logic [BYTE_W-1:0] modeReg,
  output logic [BYTE_W-1:0] ctrlReg,
  output tmrStrobe_t        stb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [CH_N-1:0] cntPipe  [SYNC_STAGES];
  logic [CH_N-1:0] gatePipe [SYNC_STAGES];
  logic [CH_N-1:0] cntPrev, fall, stepRaw;
  logic            splitMode, ctrlWr, setTf0, setTf1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) begin
        cntPipe[s]  <= '0;
        gatePipe[s] <= '0;
      end
      cntPrev <= '0;
    end else begin
      cntPipe[0]  <= cntIn;
      gatePipe[0] <= gateIn;
      for (int s = 1; s < SYNC_STAGES; s++) begin
        cntPipe[s]  <= cntPipe[s-1];
        gatePipe[s] <= gatePipe[s-1];
      end
      if (tickEn) cntPrev <= cntPipe[LAST];
    end
  end

  assign fall = {CH_N{tickEn}} & cntPrev & ~cntPipe[LAST];

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    logic [3:0] nib;
    logic       allowed;
    assign nib     = modeReg[4*ch +: 4];
    assign allowed = ctrlReg[4+2*ch] && (!nib[3] || gatePipe[LAST][ch]);
    assign stepRaw[ch] = allowed && (nib[2] ? fall[ch] : tickEn);
  end

  assign splitMode = (modeReg[1:0] == 2'd3);

  always_comb begin
    stb.mode0   = modeReg[1:0];
    stb.mode1   = modeReg[5:4];
    stb.step[0] = stepRaw[0];
    stb.step[1] = stepRaw[1] && (modeReg[5:4] != 2'd3);
    stb.stepHi0 = splitMode && tickEn && ctrlReg[6];
  end

  assign ctrlWr = regWe && (regAddr == ADDR_CTRL);
  assign setTf0 = wrapEv[0];
  assign setTf1 = splitMode ? wrapHi0 : wrapEv[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
      ctrlReg <= '0;
    end else begin
      if (regWe && regAddr == ADDR_MODE) modeReg <= regWdata;
      if (ctrlWr) begin
        ctrlReg <= {regWdata[7:4], 4'b0000};
      end else begin
        if (setTf0)          ctrlReg[5] <= 1'b1;
        else if (flagClr[0]) ctrlReg[5] <= 1'b0;
        if (setTf1)          ctrlReg[7] <= 1'b1;
        else if (flagClr[1]) ctrlReg[7] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWe,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [BYTE_W-1:0]            regWdata,
  input  tmrStrobe_t                   stb,
  output logic [CH_N-1:0][BYTE_W-1:0]  loByte,
  output logic [CH_N-1:0][BYTE_W-1:0]  hiByte,
  output logic [CH_N-1:0]              wrapEv,
  output logic                         wrapHi0
);
  logic [CH_N-1:0] hiWrap;

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_LO0 + ADDR_W'(2*ch);
    localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + 3'd1;
    logic [1:0]        mode;
    logic [BYTE_W-1:0] lo, hi, nextLo, nextHi;

    if (ch == 0) begin : g_m0
      assign mode = stb.mode0;
    end else begin : g_m1
      assign mode = stb.mode1;
    end

    always_comb begin
      nextLo = lo;
      nextHi = hi;
      wrapEv[ch] = 1'b0;
      hiWrap[ch] = 1'b0;
      if (stb.step[ch]) begin
        case (mode)
          2'd0: begin
            if (&lo[4:0]) begin
              nextLo = {lo[7:5], 5'd0};
              nextHi = hi + 8'd1;
              wrapEv[ch] = &hi;
            end else begin
              nextLo = {lo[7:5], lo[4:0] + 5'd1};
            end
          end
          2'd1: begin
            {nextHi, nextLo} = {hi, lo} + 16'd1;
            wrapEv[ch] = &{hi, lo};
          end
          2'd2: begin
            if (&lo) begin
              nextLo = hi;
              wrapEv[ch] = 1'b1;
            end else begin
              nextLo = lo + 8'd1;
            end
          end
          default: begin
            nextLo = lo + 8'd1;
            wrapEv[ch] = &lo;
          end
        endcase
      end
      if (ch == 0 && mode == 2'd3 && stb.stepHi0) begin
        nextHi = hi + 8'd1;
        hiWrap[ch] = &hi;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lo <= '0;
        hi <= '0;
      end else begin
        lo <= (regWe && regAddr == LO_ADDR) ? regWdata : nextLo;
        hi <= (regWe && regAddr == HI_ADDR) ? regWdata : nextHi;
      end
    end

    assign loByte[ch] = lo;
    assign hiByte[ch] = hi;
  end

  assign wrapHi0 = hiWrap[0];
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWdata,
  output logic [7:0]  regRdata,
  input  logic [1:0]  cntIn,
  input  logic [1:0]  gateIn,
  input  logic [1:0]  flagClr,
  output logic [1:0]  ovfFlag
);
  tmrStrobe_t                  stb;
  logic [BYTE_W-1:0]           modeReg, ctrlReg;
  logic [CH_N-1:0][BYTE_W-1:0] loByte, hiByte;
  logic [CH_N-1:0]             wrapEv;
  logic                        wrapHi0;

  twin_timer_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .cntIn(cntIn),
    .gateIn(gateIn), .flagClr(flagClr), .wrapEv(wrapEv),
    .wrapHi0(wrapHi0), .modeReg(modeReg), .ctrlReg(ctrlReg), .stb(stb)
  );

  twin_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .stb(stb), .loByte(loByte), .hiByte(hiByte),
    .wrapEv(wrapEv), .wrapHi0(wrapHi0)
  );

  always_comb begin
    case (regAddr)
      ADDR_MODE: regRdata = modeReg;
      ADDR_CTRL: regRdata = ctrlReg;
      ADDR_LO0:  regRdata = loByte[0];
      ADDR_HI0:  regRdata = hiByte[0];
      ADDR_LO1:  regRdata = loByte[1];
      ADDR_HI1:  regRdata = hiByte[1];
      default:   regRdata = '0;
    endcase
  end

  assign ovfFlag = {ctrlReg[7], ctrlReg[5]};
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       regWe,
  input logic [2:0] regAddr,
  input logic [1:0] flagClr,
  input logic [1:0] ovfFlag,
  input tmrStrobe_t stb,
  input logic [1:0] wrapEv,
  input logic       wrapHi0
);
  logic ctrlWr;
  assign ctrlWr = regWe && (regAddr == ADDR_CTRL);

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.step || stb.stepHi0) |-> tickEn); // R2
  AST_CH1_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode1 == 2'd3) |-> !stb.step[1]); // R11
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (wrapEv[0] && !ctrlWr) |=> ovfFlag[0]); // R5
  AST_HW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr[0] && !wrapEv[0] && !ctrlWr) |=> !ovfFlag[0]); // R9
  AST_SPLIT_HI_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.mode0 == 2'd3 && wrapHi0 && !ctrlWr) |=> ovfFlag[1]); // R10
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe),
  .regAddr(regAddr), .flagClr(flagClr), .ovfFlag(ovfFlag),
  .stb(stb), .wrapEv(wrapEv), .wrapHi0(wrapHi0)
);

// File: tb/twin_timer_tb.sv
module twin_timer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [1:0] cntIn = '0;
  logic [1:0] gateIn = '0;
  logic [1:0] flagClr = '0;
  logic [1:0] ovfFlag;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  twin_timer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cntIn(cntIn), .gateIn(gateIn), .flagClr(flagClr), .ovfFlag(ovfFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      tickEn = 1'b1;
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic clrPulse(input logic [1:0] m);
    @(negedge clk);
    flagClr = m;
    @(negedge clk);
    flagClr = '0;
  endtask

  // mode-2 expectation: low byte counts, reloads from high byte past 0xFF
  function automatic logic [8:0] reloadModel(input logic [7:0] lo, input logic [7:0] hi, input int n);
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (lo == 8'hFF) begin lo = hi; f = 1'b1; end
      else lo = lo + 8'd1;
    end
    return {f, lo};
  endfunction

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v, w;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 reset flags", ovfFlag, 0);

    // R12 layout: control low nibble reads 0, flags follow bits 7 and 5
    wr(3'd1, 8'hAF);
    rd(3'd1, v);
    chk("R12 ctrl readback", v, 8'hA0);
    chk("R12 flags from ctrl", ovfFlag, 2'b11);
    clrPulse(2'b11);
    chk("R9 hw clear both", ovfFlag, 0);

    // R5 mode 1 wrap
    wr(3'd0, 8'h01); wr(3'd2, 8'hFE); wr(3'd3, 8'hFF); wr(3'd1, 8'h10);
    ticks(1);
    rd(3'd2, v); chk("R5 mode1 low step", v, 8'hFF);
    chk("R5 no flag before wrap", ovfFlag, 0);
    ticks(1);
    rd(3'd2, v); rd(3'd3, w);
    chk("R5 mode1 wrap value", {w, v}, 0);
    chk("R5 mode1 flag", ovfFlag, 2'b01);

    // R2 no tick -> no count
    repeat (20) @(negedge clk);
    rd(3'd2, v); chk("R2 idle without tick", v, 0);

    // R9 hardware clear
    clrPulse(2'b01);
    chk("R9 clear flag0", ovfFlag, 0);

    // R6 mode 0
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd3, 8'h12);
    ticks(1);
    rd(3'd2, v); rd(3'd3, w);
    chk("R6 mode0 carry low", v, 8'hE0);
    chk("R6 mode0 carry high", w, 8'h13);
    wr(3'd2, 8'h1F); wr(3'd3, 8'hFF);
    ticks(1);
    rd(3'd2, v); rd(3'd3, w);
    chk("R6 mode0 wrap", {w, v}, 0);
    chk("R6 mode0 flag", ovfFlag, 2'b01);

    // R4 run bit off holds
    wr(3'd1, 8'h00); wr(3'd2, 8'h33);
    ticks(3);
    rd(3'd2, v); chk("R4 stopped holds", v, 8'h33);

    // R7 mode 2 reload on channel 1
    wr(3'd0, 8'h20); wr(3'd5, 8'h40); wr(3'd4, 8'hFE); wr(3'd1, 8'h40);
    ticks(2);
    rd(3'd4, v); rd(3'd5, w);
    chk("R7 reload low", v, 8'h40);
    chk("R7 high kept", w, 8'h40);
    chk("R7 flag1", ovfFlag, 2'b10);

    // R12 mode value 0x62: ch1 counter, ch0 timer, both reloading
    wr(3'd0, 8'h62); wr(3'd2, 8'hFE); wr(3'd3, 8'h10);
    wr(3'd4, 8'h05); wr(3'd1, 8'h50);
    ticks(2);
    rd(3'd2, v); chk("R12 ch0 timer reload", v, 8'h10);
    rd(3'd4, v); chk("R12 ch1 counter idle", v, 8'h05);

    // R3 counter edges on channel 1, mode 1 counter
    wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd1, 8'h40);
    cntIn[1] = 1'b1;
    ticks(3);
    rd(3'd4, v); chk("R3 steady high no count", v, 0);
    cntIn[1] = 1'b0;
    ticks(3);
    rd(3'd4, v); chk("R3 one fall one count", v, 1);
    cntIn[1] = 1'b1; ticks(1); cntIn[1] = 1'b0; ticks(1);
    rd(3'd4, v); chk("R3 second fall", v, 2);

    // R8 gate on channel 0
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h10);
    gateIn[0] = 1'b0;
    ticks(3);
    rd(3'd2, v); chk("R8 gated low holds", v, 0);
    gateIn[0] = 1'b1;
    ticks(2);
    rd(3'd2, v); chk("R8 gate high counts", v, 2);
    wr(3'd0, 8'h01); gateIn[0] = 1'b0;
    ticks(2);
    rd(3'd2, v); chk("R8 gate bit off ignores pin", v, 4);

    // R10 split mode on channel 0
    wr(3'd0, 8'h03); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd1, 8'h50);
    ticks(1);
    rd(3'd2, v); rd(3'd3, w);
    chk("R10 split low wrap", v, 0);
    chk("R10 split high wrap", w, 0);
    chk("R10 split flags", ovfFlag, 2'b11);
    wr(3'd1, 8'h40);
    ticks(2);
    rd(3'd2, v); rd(3'd3, w);
    chk("R10 low stopped by bit4", v, 0);
    chk("R10 high runs on bit6", w, 2);

    // R11 channel 1 mode 3 holds
    wr(3'd0, 8'h33); wr(3'd4, 8'h10); wr(3'd1, 8'h40);
    ticks(2);
    rd(3'd4, v); chk("R11 ch1 mode3 holds", v, 8'h10);

    // R5 random mode 1 runs
    for (int it = 0; it < 20; it++) begin
      logic [15:0] st;
      logic [16:0] sum;
      int n;
      st = (it % 2 == 0) ? 16'(16'hFFFF - $urandom_range(0, 15)) : 16'($urandom);
      n = $urandom_range(0, 20);
      wr(3'd0, 8'h01); wr(3'd2, st[7:0]); wr(3'd3, st[15:8]); wr(3'd1, 8'h10);
      ticks(n);
      sum = {1'b0, st} + 17'(n);
      rd(3'd2, v); rd(3'd3, w);
      chk("R5 random mode1 value", {w, v}, sum[15:0]);
      chk("R5 random mode1 flag", ovfFlag[0], sum[16]);
    end

    // R7 random mode 2 runs on channel 1
    for (int it = 0; it < 20; it++) begin
      logic [7:0] l0, h0;
      logic [8:0] e;
      int n;
      l0 = 8'(8'hFF - $urandom_range(0, 10));
      h0 = 8'(8'hF0 + $urandom_range(0, 15));
      n = $urandom_range(0, 30);
      wr(3'd0, 8'h20); wr(3'd4, l0); wr(3'd5, h0); wr(3'd1, 8'h40);
      ticks(n);
      e = reloadModel(l0, h0, n);
      rd(3'd4, v); rd(3'd5, w);
      chk("R7 random mode2 low", v, e[7:0]);
      chk("R7 random mode2 high kept", w, h0);
      chk("R7 random mode2 flag", ovfFlag[1], e[8]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule